// File: doc/BRIEF.md
# Dual Threshold and Rate-of-Change Alarm

This block watches two independently configured sample streams and raises a sticky alarm flag for each when the stream crosses a programmed limit. Every alarm channel picks one of eight 14-bit sources and chooses between its raw and its filtered version. It then compares either the sample itself (static mode) or the change of the sample across a programmable window (rate mode) against a signed 14-bit magnitude. One bit of the magnitude word chooses whether the alarm fires above or below the limit.

The block evaluates the comparison only in the cycle that `smp_vld` marks. A flag that sets stays set until software reads the status, which it signals with `stat_rd`. If the condition still holds at the next sample, the flag sets again. A shared indicator request reflects whether any flag is set. It has its own enable and its own polarity, so a general-purpose pin can show an alarm without software polling.

Top module: `dual_alarm_unit`

## Requirements
- R1: After a synchronous active-low reset, both alarm flags are 0. `ind_lvl` then shows the idle level, which is the inverse of `alm_ctl[0]`.
- R2: In static mode, a magnitude word with bit 15 = 1 sets the flag when the signed 14-bit sample is strictly greater than the signed value in bits 13:0. Bit 15 = 0 sets it when the sample is strictly less. An equal sample never sets the flag. The flag is visible in the cycle after the `smp_vld` cycle.
- R3: In rate mode (alarm 1: `alm_ctl[6]`, alarm 2: `alm_ctl[7]`), the value compared is the current sample minus the sample taken N samples earlier. This difference is formed in 15 bits and never wraps, so the extremes +8191 - (-8192) give +16383.
- R4: The 8-bit window code gives N. Codes 0 and 1 both mean N = 1, and any other code is N itself.
- R5: A rate comparison cannot set the flag until N samples have been captured. The count restarts after reset and after any change to that alarm's source, filter bit, rate bit or window code.
- R6: Alarm 1 takes its source code from `alm_ctl[15:12]` and alarm 2 from `alm_ctl[11:8]`. Codes 0 to 7 select supply, X accel, Y accel, aux ADC, temperature, X incline, Y incline and rotation. Codes 8 to 15 never set the flag.
- R7: Source codes 5, 6 and 7 always use the filtered stream. Codes 0 to 4 use the filtered stream when the channel's filter bit is 1 (alarm 1: `alm_ctl[2]`, alarm 2: `alm_ctl[3]`), and the raw stream otherwise. Source k sits at bits [14k+13:14k] of `src_raw` and `src_filt`.
- R8: A `stat_rd` pulse clears both flags at the next edge. If a sample meeting the condition arrives in the same cycle, that flag reads 1.
- R9: A set flag stays set, whatever later samples do, until `stat_rd` is pulsed.
- R10: `ind_oe` follows `alm_ctl[1]`. When `alm_ctl[1]` = 1 and at least one flag is set, `ind_lvl` equals the polarity bit `alm_ctl[0]`. In every other case it is the inverse of that bit.
- R11: The two channels are independent. Bit 0 of `alm_flag` belongs to alarm 1 and bit 1 to alarm 2, and each bit reacts only to its own source, magnitude and window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Marks the cycle in which a new set of samples is present |
| src_raw | input | 112 | Eight unfiltered 14-bit sources, source k at bits 14k+13:14k |
| src_filt | input | 112 | Eight filtered 14-bit sources, same layout |
| alm_ctl | input | 16 | Sources, rate enables, filter bits, indicator enable and polarity |
| mag1 | input | 16 | Alarm 1 magnitude: bit 15 direction, bits 13:0 signed limit |
| mag2 | input | 16 | Alarm 2 magnitude, same layout |
| win1 | input | 8 | Alarm 1 rate window code |
| win2 | input | 8 | Alarm 2 rate window code |
| stat_rd | input | 1 | Status read strobe, clears the flags |
| alm_flag | output | 2 | Sticky alarm flags, bit 0 alarm 1, bit 1 alarm 2 |
| ind_oe | output | 1 | Indicator drive enable |
| ind_lvl | output | 1 | Indicator line level |

## Verification
The bench uses the default parameters: 14-bit samples, eight sources and an 8-bit window code. With an 8-bit window code, each history buffer has 256 entries. Windows of 1, 2 and 3 are enough to observe the difference against an older entry, the aliasing of codes 0 and 1, and the suppression while the buffer fills. The full-scale operands -8192 and +8191 are in reach, so the stimulus can expose a difference that wraps.

// File: rtl/alm_pkg.sv
// Package alm_pkg
// Shared constants and the source encoding used by the dual alarm unit.
// Assumes every source delivers a two's-complement sample of SMP_W bits.
package alm_pkg;
    localparam int SMP_W = 14;
    localparam int NSRC  = 8;
    localparam int CNT_W = 8;

    // Source codes in the order the selector decodes them.
    typedef enum logic [2:0] {
        SRC_SUPPLY = 3'd0,
        SRC_XACC   = 3'd1,
        SRC_YACC   = 3'd2,
        SRC_AUX    = 3'd3,
        SRC_TEMP   = 3'd4,
        SRC_XINC   = 3'd5,
        SRC_YINC   = 3'd6,
        SRC_ROT    = 3'd7
    } alm_src_e;

    // First source code whose data is always taken filtered.
    localparam int FORCE_FILT_FROM = int'(SRC_XINC);
endpackage

// File: rtl/alm_src_sel.sv
// Module alm_src_sel
// Picks one sample from the raw or filtered source bundles.
// Assumes the bundles are packed with source k at [k*SMP_W +: SMP_W].
// Codes at or above NSRC are reported through sel_ok = 0.
module alm_src_sel #(
    parameter int SMP_W = alm_pkg::SMP_W,
    parameter int NSRC  = alm_pkg::NSRC,
    parameter int FFROM = alm_pkg::FORCE_FILT_FROM
) (
    input  logic [NSRC*SMP_W-1:0] raw,
    input  logic [NSRC*SMP_W-1:0] filt,
    input  logic [3:0]            sel,
    input  logic                  filt_en,
    output logic [SMP_W-1:0]      smp,
    output logic                  sel_ok
);
    localparam int IDX_W = $clog2(NSRC);

    logic [IDX_W-1:0] idx;
    logic             use_filt;

    // Decode the source index and decide raw versus filtered data.
    always_comb begin
        idx      = sel[IDX_W-1:0];
        sel_ok   = (int'(sel) < NSRC);
        use_filt = filt_en || (int'(sel) >= FFROM);
        smp      = use_filt ? filt[idx*SMP_W +: SMP_W] : raw[idx*SMP_W +: SMP_W];
    end
endmodule

// File: rtl/alm_history.sv
// Module alm_history
// Circular buffer of past samples and a saturating fill counter.
// Holds 2**CNT_W entries, so any window code up to its maximum is reachable.
// Assumes clr is high for exactly the cycles in which the channel config changed.
module alm_history #(
    parameter int SMP_W = alm_pkg::SMP_W,
    parameter int CNT_W = alm_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             clr,
    input  logic [SMP_W-1:0] din,
    input  logic [CNT_W-1:0] win,
    output logic [SMP_W-1:0] dout,
    output logic             ready
);
    localparam int DEPTH = 1 << CNT_W;
    localparam logic [CNT_W-1:0] FILL_MAX = {CNT_W{1'b1}};

    logic [SMP_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0] wr_ptr;
    logic [CNT_W-1:0] rd_ptr;
    logic [CNT_W-1:0] fill_q;
    logic [CNT_W-1:0] n_eff;

    // Window codes 0 and 1 both select a one-sample distance.
    always_comb begin
        n_eff  = (win == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : win;
        rd_ptr = wr_ptr - n_eff;
        dout   = mem[rd_ptr];
        ready  = (fill_q >= n_eff) && !clr;
    end

    // Store each valid sample at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= din;
        end
    end

    // Advance the write pointer and count captured samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            fill_q <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (clr) begin
                fill_q <= wr_en ? {{(CNT_W-1){1'b0}}, 1'b1} : '0;
            end else if (wr_en && fill_q != FILL_MAX) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    // A config change with no sample leaves the buffer not ready.
    p_clr_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wr_en) |=> !ready)
        else $error("p_clr_blocks_r5");
endmodule

// File: rtl/alm_compare.sv
// Module alm_compare
// Signed comparison of a sample, or of its difference to an older sample,
// against a limit. Operands are widened by one bit, so the difference
// cannot overflow.
module alm_compare #(
    parameter int SMP_W = alm_pkg::SMP_W
) (
    input  logic [SMP_W-1:0] cur,
    input  logic [SMP_W-1:0] old,
    input  logic [SMP_W-1:0] thr,
    input  logic             gt,
    input  logic             rate,
    output logic [SMP_W:0]   diff,
    output logic             cond
);
    logic signed [SMP_W:0] cur_x;
    logic signed [SMP_W:0] old_x;
    logic signed [SMP_W:0] thr_x;
    logic signed [SMP_W:0] lhs;

    // Sign-extend the operands, pick the compared value and test it.
    always_comb begin
        cur_x = {cur[SMP_W-1], cur};
        old_x = {old[SMP_W-1], old};
        thr_x = {thr[SMP_W-1], thr};
        diff  = cur_x - old_x;
        lhs   = rate ? signed'(diff) : cur_x;
        cond  = gt ? (lhs > thr_x) : (lhs < thr_x);
    end
endmodule

// File: rtl/alm_channel.sv
// Module alm_channel
// One alarm channel: source selection, sample history and comparison.
// hit is a single-cycle pulse in a smp_vld cycle whose sample meets the
// condition. Rate mode is held off while the history is not ready.
module alm_channel #(
    parameter int SMP_W = alm_pkg::SMP_W,
    parameter int NSRC  = alm_pkg::NSRC,
    parameter int CNT_W = alm_pkg::CNT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_vld,
    input  logic [NSRC*SMP_W-1:0] raw,
    input  logic [NSRC*SMP_W-1:0] filt,
    input  logic [3:0]            src_sel,
    input  logic                  filt_en,
    input  logic                  rate_en,
    input  logic                  gt,
    input  logic [SMP_W-1:0]      thr,
    input  logic [CNT_W-1:0]      win,
    output logic                  hit
);
    localparam int CFG_W = 4 + 1 + 1 + CNT_W;

    logic [SMP_W-1:0] cur;
    logic [SMP_W-1:0] old;
    logic [SMP_W:0]   diff;
    logic             sel_ok;
    logic             ready;
    logic             cond;
    logic [CFG_W-1:0] cfg;
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_chg;

    alm_src_sel #(.SMP_W(SMP_W), .NSRC(NSRC)) i_sel (
        .raw     (raw),
        .filt    (filt),
        .sel     (src_sel),
        .filt_en (filt_en),
        .smp     (cur),
        .sel_ok  (sel_ok)
    );

    alm_history #(.SMP_W(SMP_W), .CNT_W(CNT_W)) i_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (smp_vld),
        .clr   (cfg_chg),
        .din   (cur),
        .win   (win),
        .dout  (old),
        .ready (ready)
    );

    alm_compare #(.SMP_W(SMP_W)) i_cmp (
        .cur  (cur),
        .old  (old),
        .thr  (thr),
        .gt   (gt),
        .rate (rate_en),
        .diff (diff),
        .cond (cond)
    );

    // Detect any change of the settings that define the history contents.
    always_comb begin
        cfg     = {src_sel, filt_en, rate_en, win};
        cfg_chg = (cfg != cfg_q);
    end

    // Remember the settings seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg;
        end
    end

    // Qualify the comparison with sample valid, source range and readiness.
    always_comb begin
        hit = smp_vld && sel_ok && cond && (!rate_en || ready);
    end

    // Equal-signed operands must give a difference that fits SMP_W bits.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && rate_en && ready && (cur[SMP_W-1] == old[SMP_W-1]))
            |-> (diff[SMP_W] == diff[SMP_W-1]))
        else $error("p_no_overflow_r3");
endmodule

// File: rtl/dual_alarm_unit.sv
// Module dual_alarm_unit
// Two alarm channels with sticky flags that clear on read, and a shared
// indicator request.
// Assumes stat_rd is a one-cycle strobe from the register read path. A
// condition met in the same cycle as a read wins over the clear.
module dual_alarm_unit #(
    parameter int SMP_W = alm_pkg::SMP_W,
    parameter int NSRC  = alm_pkg::NSRC,
    parameter int CNT_W = alm_pkg::CNT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_vld,
    input  logic [NSRC*SMP_W-1:0] src_raw,
    input  logic [NSRC*SMP_W-1:0] src_filt,
    input  logic [15:0]           alm_ctl,
    input  logic [15:0]           mag1,
    input  logic [15:0]           mag2,
    input  logic [CNT_W-1:0]      win1,
    input  logic [CNT_W-1:0]      win2,
    input  logic                  stat_rd,
    output logic [1:0]            alm_flag,
    output logic                  ind_oe,
    output logic                  ind_lvl
);
    localparam int NCH = 2;

    logic [3:0]       sel_a  [NCH];
    logic             filt_a [NCH];
    logic             rate_a [NCH];
    logic [15:0]      mag_a  [NCH];
    logic [CNT_W-1:0] win_a  [NCH];
    logic [NCH-1:0]   hit;
    logic             ind_pol;
    logic             unused_bits;

    // Map the control word fields onto per-channel settings.
    always_comb begin
        sel_a[0]    = alm_ctl[15:12];
        sel_a[1]    = alm_ctl[11:8];
        rate_a[0]   = alm_ctl[6];
        rate_a[1]   = alm_ctl[7];
        filt_a[0]   = alm_ctl[2];
        filt_a[1]   = alm_ctl[3];
        mag_a[0]    = mag1;
        mag_a[1]    = mag2;
        win_a[0]    = win1;
        win_a[1]    = win2;
        ind_pol     = alm_ctl[0];
        unused_bits = ^{alm_ctl[5:4], mag1[14], mag2[14]};
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        alm_channel #(.SMP_W(SMP_W), .NSRC(NSRC), .CNT_W(CNT_W)) i_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_vld (smp_vld),
            .raw     (src_raw),
            .filt    (src_filt),
            .src_sel (sel_a[g]),
            .filt_en (filt_a[g]),
            .rate_en (rate_a[g]),
            .gt      (mag_a[g][15]),
            .thr     (mag_a[g][SMP_W-1:0]),
            .win     (win_a[g]),
            .hit     (hit[g])
        );
    end

    // Sticky flags: set on a hit, cleared by a read unless a hit coincides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_flag <= '0;
        end else begin
            alm_flag <= hit | (alm_flag & {NCH{~stat_rd}});
        end
    end

    // Drive the indicator request from the flags and its polarity.
    always_comb begin
        ind_oe  = alm_ctl[1];
        ind_lvl = (ind_oe && (alm_flag != '0)) ? ind_pol : ~ind_pol;
    end

    // A flag can only rise after a valid sample.
    p_rise_needs_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> ((alm_flag & ~$past(alm_flag)) == '0))
        else $error("p_rise_needs_sample_r2");

    // Without a read, no flag drops.
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((~alm_flag & $past(alm_flag)) == '0))
        else $error("p_sticky_r9");

    // A read without a sample leaves every flag clear.
    p_clear_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !smp_vld) |=> (alm_flag == '0))
        else $error("p_clear_on_read_r8");

    // With no flag set, the indicator rests at its idle level.
    p_ind_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_flag == '0) |-> (ind_lvl == !alm_ctl[0]))
        else $error("p_ind_idle_r10");
endmodule

// File: tb/test_dual_alarm_unit.sv
// Directed bench for dual_alarm_unit. Inputs change at the falling edge
// and outputs are checked at the falling edge after the capturing rise.
module test_dual_alarm_unit;
    localparam int SW = 14;
    localparam int NS = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           smp_vld = 1'b0;
    logic [NS*SW-1:0] src_raw;
    logic [NS*SW-1:0] src_filt;
    logic [15:0]    alm_ctl = '0;
    logic [15:0]    mag1 = '0;
    logic [15:0]    mag2 = '0;
    logic [7:0]     win1 = 8'd1;
    logic [7:0]     win2 = 8'd1;
    logic           stat_rd = 1'b0;
    logic [1:0]     alm_flag;
    logic           ind_oe;
    logic           ind_lvl;

    logic [SW-1:0]  raw_v  [NS];
    logic [SW-1:0]  filt_v [NS];

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    // Pack the per-source values into the bundles.
    always_comb begin
        for (int k = 0; k < NS; k++) begin
            src_raw[k*SW +: SW]  = raw_v[k];
            src_filt[k*SW +: SW] = filt_v[k];
        end
    end

    dual_alarm_unit i_dual_alarm_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .src_raw  (src_raw),
        .src_filt (src_filt),
        .alm_ctl  (alm_ctl),
        .mag1     (mag1),
        .mag2     (mag2),
        .win1     (win1),
        .win2     (win2),
        .stat_rd  (stat_rd),
        .alm_flag (alm_flag),
        .ind_oe   (ind_oe),
        .ind_lvl  (ind_lvl)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_all(input logic [SW-1:0] r, input logic [SW-1:0] f);
        for (int k = 0; k < NS; k++) begin
            raw_v[k]  = r;
            filt_v[k] = f;
        end
    endtask

    // One sample cycle; afterwards the flags show its result.
    task automatic do_sample();
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic do_read();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 flags after reset", alm_flag, 2'b00);
        chk("R1 indicator idle level", ind_lvl, 1'b1);
        chk("R10 ind_oe off", ind_oe, 1'b0);
    endtask

    task automatic t_static();
        alm_ctl = 16'h1000;            // alarm 1 on X accel, raw, static
        mag1    = 16'h8000 | 16'd100;  // greater than 100
        idle();
        raw_v[1] = 14'd100; do_sample();
        chk("R2 equal does not set", alm_flag[0], 1'b0);
        raw_v[1] = 14'd101; do_sample();
        chk("R2 above limit sets", alm_flag[0], 1'b1);
        raw_v[1] = 14'd0; do_sample();
        chk("R9 flag sticky", alm_flag[0], 1'b1);
        do_read();
        chk("R8 read clears", alm_flag[0], 1'b0);
        mag1 = 16'h3FCE;               // less than -50
        raw_v[1] = 14'h3FCE; do_sample();
        chk("R2 equal negative no set", alm_flag[0], 1'b0);
        raw_v[1] = 14'h3FCD; do_sample();
        chk("R2 below negative limit sets", alm_flag[0], 1'b1);
    endtask

    task automatic t_read_race();
        raw_v[1] = 14'h3F00;           // still below -50
        stat_rd = 1'b1; smp_vld = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0; smp_vld = 1'b0;
        chk("R8 hit beats read", alm_flag[0], 1'b1);
        raw_v[1] = 14'd0;
        stat_rd = 1'b1; smp_vld = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0; smp_vld = 1'b0;
        chk("R8 cleared when condition gone", alm_flag[0], 1'b0);
    endtask

    task automatic t_rate_fill();
        alm_ctl = 16'h1040;            // X accel, rate mode
        win1    = 8'd3;
        mag1    = 16'h8000 | 16'd10;
        idle();
        raw_v[1] = 14'd0;    do_sample();
        raw_v[1] = 14'd5000; do_sample();
        chk("R5 suppressed at fill 1", alm_flag[0], 1'b0);
        do_sample();
        chk("R5 suppressed at fill 2", alm_flag[0], 1'b0);
        do_sample();
        chk("R3 window 3 difference sets", alm_flag[0], 1'b1);
        do_read();
        do_sample();
        chk("R3 no change over window", alm_flag[0], 1'b0);
    endtask

    task automatic t_rate_window();
        win1 = 8'd0;
        mag1 = 16'h8000 | 16'h1FFF;    // greater than 8191
        idle();
        raw_v[1] = 14'h2000; do_sample();
        raw_v[1] = 14'h1FFF; do_sample();
        chk("R3 full scale difference no wrap", alm_flag[0], 1'b1);
        chk("R4 code 0 acts as one", alm_flag[0], 1'b1);
        do_read();
        win1 = 8'd1;
        mag1 = 16'h3FEC;               // less than -20
        idle();
        raw_v[1] = 14'd100; do_sample();
        raw_v[1] = 14'd50;  do_sample();
        chk("R4 code 1 one sample negative rate", alm_flag[0], 1'b1);
        do_read();
        win1 = 8'd2;
        mag1 = 16'h8000 | 16'd40;
        idle();
        raw_v[1] = 14'd0;   do_sample();
        raw_v[1] = 14'd100; do_sample();
        do_read();
        raw_v[1] = 14'd50;  do_sample();
        chk("R4 window 2 uses older entry", alm_flag[0], 1'b1);
        do_read();
    endtask

    task automatic t_source();
        alm_ctl = 16'h6000;            // Y incline, filter bit clear
        mag1    = 16'h8000 | 16'd100;
        set_all(14'd500, 14'd0);
        idle(); do_sample();
        chk("R7 incline forced filtered", alm_flag[0], 1'b0);
        filt_v[6] = 14'd500; raw_v[6] = 14'd0;
        do_sample();
        chk("R7 incline filtered value used", alm_flag[0], 1'b1);
        do_read();
        set_all(14'd500, 14'd0);
        alm_ctl = 16'h1000; idle(); do_sample();
        chk("R6 code 1 raw selected", alm_flag[0], 1'b1);
        do_read();
        alm_ctl = 16'h1004; idle(); do_sample();
        chk("R7 filter bit picks filtered", alm_flag[0], 1'b0);
        alm_ctl = 16'h9000; set_all(14'd500, 14'd500); idle(); do_sample();
        chk("R6 code 9 never sets", alm_flag[0], 1'b0);
    endtask

    task automatic t_indep_ind();
        set_all(14'd0, 14'd0);
        alm_ctl = 16'h0200;            // alarm1 supply, alarm2 Y accel
        mag1 = 16'h8000 | 16'd100;
        mag2 = 16'h8000 | 16'd100;
        raw_v[2] = 14'd300;
        idle(); do_sample();
        chk("R11 only alarm 2 set", alm_flag, 2'b10);
        alm_ctl = 16'h0203; idle();
        chk("R10 enabled high active", ind_lvl, 1'b1);
        chk("R10 ind_oe on", ind_oe, 1'b1);
        alm_ctl = 16'h0202; idle();
        chk("R10 enabled low active", ind_lvl, 1'b0);
        alm_ctl = 16'h0201; idle();
        chk("R10 disabled idle level", ind_lvl, 1'b0);
        alm_ctl = 16'h0203; do_read();
        chk("R10 no flag idle level", ind_lvl, 1'b0);
    endtask

    initial begin
        set_all('0, '0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        t_reset();
        t_static();
        t_read_race();
        t_rate_fill();
        t_rate_window();
        t_source();
        t_indep_ind();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule